// File: doc/BRIEF.md
# Precise Exception Flush Controller

This block is the exception side of the hazard logic in a five-stage in-order pipeline. It keeps a valid bit and a program counter for each instruction past fetch: decode, execute, and a parameterised tail of later stages, memory and write-back by default. Two stages can report a fault. Decode can flag an opcode it does not recognise, and execute can flag an arithmetic overflow. At most one fault is accepted per cycle, and the accepted fault is always the oldest one reported.

In the cycle a fault is accepted, the block does the following:
- It asserts flush strobes for the stages that hold the faulting instruction and every younger one.
- It asserts a write-kill when the fault came from execute.
- It steers the next fetch to the handler address instead of the sequential address.
- It pulses a strobe together with the faulting PC and a cause code, so that outside registers can capture them.

Instructions already in the tail stages are older than the fault. They drain and complete as normal. This makes the exception precise.

The fetch path and the stall request are plain level signals, sampled on every rising clock edge. The block has no handshake of its own. A stall holds the instruction in decode and puts a bubble into execute. A stall has no effect in a cycle where a fault is accepted.

Top module: `excf_ctrl`

## Requirements
- R1: After reset, every stage valid output is 0, and take_exc_o, the flush outputs and pc_sel_handler_o are all 0.
- R2: When ex_valid_o is 1 and ex_ovf_i is 1, the following outputs are all 1 in the same cycle: take_exc_o, flush_if_o, flush_id_o, flush_ex_o and wr_kill_o. After the next edge, id_valid_o, ex_valid_o and mem_valid_o are 0.
- R3: When id_valid_o is 1 and id_undef_i is 1, with no accepted execute fault, take_exc_o, flush_if_o and flush_id_o are 1, while flush_ex_o and wr_kill_o are 0. After the next edge, id_valid_o and ex_valid_o are 0, and the instruction that was in execute is in memory with its PC.
- R4: When decode and execute both report a fault in the same cycle, the execute fault wins. In that case cause_o is the overflow code and epc_o is ex_pc_o.
- R5: The tail stages always advance. Each edge moves the valid bit and PC of the memory stage into the write-back stage, whether or not a fault is taken.
- R6: pc_sel_handler_o equals take_exc_o in the same cycle, so the fetch right after the flush is the handler's first instruction.
- R7: cause_o is 2'b00 when no fault is taken, 2'b01 for an undefined opcode, and 2'b10 for an overflow. When take_exc_o is 1, epc_o is the PC of the faulting instruction.
- R8: A fault input from a stage whose valid bit is 0 is ignored. take_exc_o stays 0 and the pipeline advances as normal.
- R9: With stall_i at 1 and no fault, decode keeps its valid bit and PC, and execute gets a bubble. When a fault is taken, stall_i is ignored.
- R10: With no stall and no fault, a valid fetch (if_valid_i, if_pc_i) reaches decode after one edge and execute after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_valid_i | input | 1 | A fetched instruction is present |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| stall_i | input | 1 | Hold decode and put a bubble into execute |
| id_undef_i | input | 1 | Decode reports an undefined opcode |
| ex_ovf_i | input | 1 | Execute reports an arithmetic overflow |
| flush_if_o | output | 1 | Discard the instruction being fetched |
| flush_id_o | output | 1 | Discard the decode stage |
| flush_ex_o | output | 1 | Discard the execute stage |
| wr_kill_o | output | 1 | Suppress the faulting instruction's register write |
| pc_sel_handler_o | output | 1 | Next fetch uses the handler address |
| take_exc_o | output | 1 | One-cycle strobe: a fault is accepted |
| epc_o | output | PC_W | PC of the faulting instruction |
| cause_o | output | 2 | Fault cause code |
| id_valid_o | output | 1 | Decode stage valid |
| id_pc_o | output | PC_W | Decode stage PC |
| ex_valid_o | output | 1 | Execute stage valid |
| ex_pc_o | output | PC_W | Execute stage PC |
| mem_valid_o | output | 1 | Memory stage valid |
| mem_pc_o | output | PC_W | Memory stage PC |
| wb_valid_o | output | 1 | Write-back stage valid, used as the register write enable |
| wb_pc_o | output | PC_W | Write-back stage PC |

## Verification
A corrupted valid bit in decode or execute shows up on the next edge in two ways. The stage valid outputs disagree with the model, and a fault that should have been taken or ignored flips take_exc_o in that same cycle. A wrong priority or PC mux shows at once on epc_o and cause_o in the cycle of the fault. A failure to clear the faulting instruction shows up on the next edge, when mem_valid_o or wb_valid_o rise where they should not, which would mean an extra register write. The bench compares every output with a cycle model in every cycle, so any such divergence is reported at the first cycle where it can be seen.

// File: rtl/excf_pkg.sv
package excf_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_UNDEF = 2'b01,
    CAUSE_OVF   = 2'b10
  } cause_e;
endpackage

// File: rtl/excf_arbiter.sv
module excf_arbiter
  import excf_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            id_v,
  input  logic            id_undef,
  input  logic [PC_W-1:0] id_pc,
  input  logic            ex_v,
  input  logic            ex_ovf,
  input  logic [PC_W-1:0] ex_pc,
  output logic            take,
  output logic            from_ex,
  output logic [PC_W-1:0] epc,
  output cause_e          cause
);
  logic id_hit;

  // the older instruction (execute) has priority
  always_comb begin
    from_ex = ex_v & ex_ovf;
    id_hit  = id_v & id_undef & ~from_ex;
    take    = from_ex | id_hit;
    if (from_ex) begin
      epc   = ex_pc;
      cause = CAUSE_OVF;
    end else if (id_hit) begin
      epc   = id_pc;
      cause = CAUSE_UNDEF;
    end else begin
      epc   = '0;
      cause = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/excf_front.sv
module excf_front #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            take,
  input  logic            if_valid,
  input  logic [PC_W-1:0] if_pc,
  output logic            id_v,
  output logic [PC_W-1:0] id_pc,
  output logic            ex_v,
  output logic [PC_W-1:0] ex_pc
);
  logic hold;

  always_comb hold = stall & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_v  <= 1'b0;
      id_pc <= '0;
      ex_v  <= 1'b0;
      ex_pc <= '0;
    end else begin
      ex_v  <= id_v & ~take & ~hold;
      ex_pc <= id_pc;
      if (take) begin
        id_v  <= 1'b0;
        id_pc <= if_pc;
      end else if (!hold) begin
        id_v  <= if_valid;
        id_pc <= if_pc;
      end
    end
  end
endmodule

// File: rtl/excf_tail.sv
module excf_tail #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_v,
  input  logic [PC_W-1:0]            in_pc,
  output logic [DEPTH-1:0]           v_q,
  output logic [DEPTH-1:0][PC_W-1:0] pc_q
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic            src_v;
    logic [PC_W-1:0] src_pc;
    if (s == 0) begin : g_head
      always_comb begin
        src_v  = in_v;
        src_pc = in_pc;
      end
    end else begin : g_link
      always_comb begin
        src_v  = v_q[s-1];
        src_pc = pc_q[s-1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s]  <= 1'b0;
        pc_q[s] <= '0;
      end else begin
        v_q[s]  <= src_v;
        pc_q[s] <= src_pc;
      end
    end
  end
endmodule

// File: rtl/excf_ctrl.sv
module excf_ctrl
  import excf_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int TAIL_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic            stall_i,
  input  logic            id_undef_i,
  input  logic            ex_ovf_i,
  output logic            flush_if_o,
  output logic            flush_id_o,
  output logic            flush_ex_o,
  output logic            wr_kill_o,
  output logic            pc_sel_handler_o,
  output logic            take_exc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [1:0]      cause_o,
  output logic            id_valid_o,
  output logic [PC_W-1:0] id_pc_o,
  output logic            ex_valid_o,
  output logic [PC_W-1:0] ex_pc_o,
  output logic            mem_valid_o,
  output logic [PC_W-1:0] mem_pc_o,
  output logic            wb_valid_o,
  output logic [PC_W-1:0] wb_pc_o
);
  localparam int LAST = TAIL_DEPTH - 1;

  logic                            take, from_ex;
  logic [PC_W-1:0]                 epc;
  cause_e                          cause;
  logic                            id_v, ex_v;
  logic [PC_W-1:0]                 id_pc, ex_pc;
  logic [TAIL_DEPTH-1:0]           tail_v;
  logic [TAIL_DEPTH-1:0][PC_W-1:0] tail_pc;

  excf_arbiter #(.PC_W(PC_W)) u_arb (
    .id_v(id_v), .id_undef(id_undef_i), .id_pc(id_pc),
    .ex_v(ex_v), .ex_ovf(ex_ovf_i), .ex_pc(ex_pc),
    .take(take), .from_ex(from_ex), .epc(epc), .cause(cause)
  );

  excf_front #(.PC_W(PC_W)) u_front (
    .clk(clk), .rst_n(rst_n), .stall(stall_i), .take(take),
    .if_valid(if_valid_i), .if_pc(if_pc_i),
    .id_v(id_v), .id_pc(id_pc), .ex_v(ex_v), .ex_pc(ex_pc)
  );

  // a faulting execute instruction enters the tail as a nop
  excf_tail #(.PC_W(PC_W), .DEPTH(TAIL_DEPTH)) u_tail (
    .clk(clk), .rst_n(rst_n),
    .in_v(ex_v & ~from_ex), .in_pc(ex_pc),
    .v_q(tail_v), .pc_q(tail_pc)
  );

  always_comb begin
    flush_if_o       = take;
    flush_id_o       = take;
    flush_ex_o       = from_ex;
    wr_kill_o        = from_ex;
    pc_sel_handler_o = take;
    take_exc_o       = take;
    epc_o            = epc;
    cause_o          = cause;
    id_valid_o       = id_v;
    id_pc_o          = id_pc;
    ex_valid_o       = ex_v;
    ex_pc_o          = ex_pc;
    mem_valid_o      = tail_v[0];
    mem_pc_o         = tail_pc[0];
    wb_valid_o       = tail_v[LAST];
    wb_pc_o          = tail_pc[LAST];
  end
endmodule

// File: rtl/excf_ctrl_checker.sv
module excf_ctrl_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall_i,
  input logic            id_undef_i,
  input logic            ex_ovf_i,
  input logic            flush_if_o,
  input logic            flush_id_o,
  input logic            flush_ex_o,
  input logic            wr_kill_o,
  input logic            pc_sel_handler_o,
  input logic            take_exc_o,
  input logic [PC_W-1:0] epc_o,
  input logic [1:0]      cause_o,
  input logic            id_valid_o,
  input logic [PC_W-1:0] id_pc_o,
  input logic            ex_valid_o,
  input logic [PC_W-1:0] ex_pc_o,
  input logic            mem_valid_o,
  input logic            wb_valid_o
);
  assert_ovf_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_o && ex_ovf_i) |-> (take_exc_o && flush_if_o && flush_id_o && flush_ex_o && wr_kill_o));

  assert_ovf_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_o && ex_ovf_i) |=> (!id_valid_o && !ex_valid_o && !mem_valid_o));

  assert_undef_keeps_ex_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_o && id_undef_i && !(ex_valid_o && ex_ovf_i)) |-> (take_exc_o && !flush_ex_o && !wr_kill_o));

  assert_undef_older_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc_o && !flush_ex_o && ex_valid_o) |=> mem_valid_o);

  assert_ex_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_o && ex_ovf_i && id_valid_o && id_undef_i) |-> (cause_o == 2'b10 && epc_o == ex_pc_o));

  assert_tail_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |=> wb_valid_o);

  assert_handler_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_handler_o == take_exc_o);

  assert_cause_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc_o |-> (cause_o == 2'b00));

  assert_invalid_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid_o && !id_valid_o) |-> !take_exc_o);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !take_exc_o) |=> ($stable(id_valid_o) && $stable(id_pc_o) && !ex_valid_o));

  assert_stall_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc_o |=> (!id_valid_o && !ex_valid_o));
endmodule

bind excf_ctrl excf_ctrl_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .id_undef_i(id_undef_i),
  .ex_ovf_i(ex_ovf_i), .flush_if_o(flush_if_o), .flush_id_o(flush_id_o),
  .flush_ex_o(flush_ex_o), .wr_kill_o(wr_kill_o),
  .pc_sel_handler_o(pc_sel_handler_o), .take_exc_o(take_exc_o),
  .epc_o(epc_o), .cause_o(cause_o), .id_valid_o(id_valid_o),
  .id_pc_o(id_pc_o), .ex_valid_o(ex_valid_o), .ex_pc_o(ex_pc_o),
  .mem_valid_o(mem_valid_o), .wb_valid_o(wb_valid_o)
);

// File: tb/tb_excf_ctrl.sv
module tb_excf_ctrl;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid_i = 1'b0, stall_i = 1'b0, id_undef_i = 1'b0, ex_ovf_i = 1'b0;
  logic [PC_W-1:0] if_pc_i = '0;
  logic flush_if_o, flush_id_o, flush_ex_o, wr_kill_o, pc_sel_handler_o, take_exc_o;
  logic [PC_W-1:0] epc_o, id_pc_o, ex_pc_o, mem_pc_o, wb_pc_o;
  logic [1:0] cause_o;
  logic id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  excf_ctrl #(.PC_W(PC_W), .TAIL_DEPTH(2)) dut (.*);

  // reference state: index 0 decode, 1 execute, 2 memory, 3 write-back
  logic            m_v  [4];
  logic [PC_W-1:0] m_pc [4];

  task automatic chk(input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic f_ex_hit(input logic ovf);
    return m_v[1] & ovf;
  endfunction

  function automatic logic f_id_hit(input logic und, input logic ovf);
    return m_v[0] & und & ~f_ex_hit(ovf);
  endfunction

  // drive at negedge, check shortly after, then advance model at posedge
  task automatic cyc(input logic fv, input logic [PC_W-1:0] fpc, input logic st,
                     input logic und, input logic ovf);
    logic eex, eid, tk;
    if_valid_i = fv; if_pc_i = fpc; stall_i = st; id_undef_i = und; ex_ovf_i = ovf;
    #1;
    eex = f_ex_hit(ovf);
    eid = f_id_hit(und, ovf);
    tk  = eex | eid;
    chk(PC_W'(take_exc_o), PC_W'(tk), "R2/R3/R8 take");
    chk(PC_W'(flush_if_o), PC_W'(tk), "R2 flush_if");
    chk(PC_W'(flush_id_o), PC_W'(tk), "R3 flush_id");
    chk(PC_W'(flush_ex_o), PC_W'(eex), "R2 flush_ex");
    chk(PC_W'(wr_kill_o), PC_W'(eex), "R2 wr_kill");
    chk(PC_W'(pc_sel_handler_o), PC_W'(tk), "R6 pc_sel");
    chk(PC_W'(cause_o), PC_W'(eex ? 2'b10 : eid ? 2'b01 : 2'b00), "R4/R7 cause");
    if (tk) chk(epc_o, eex ? m_pc[1] : m_pc[0], "R4/R7 epc");
    chk(PC_W'(id_valid_o), PC_W'(m_v[0]), "R9/R10 id_valid");
    chk(PC_W'(ex_valid_o), PC_W'(m_v[1]), "R10 ex_valid");
    chk(PC_W'(mem_valid_o), PC_W'(m_v[2]), "R2/R3 mem_valid");
    chk(PC_W'(wb_valid_o), PC_W'(m_v[3]), "R5 wb_valid");
    if (m_v[0]) chk(id_pc_o, m_pc[0], "R9 id_pc");
    if (m_v[1]) chk(ex_pc_o, m_pc[1], "R10 ex_pc");
    if (m_v[2]) chk(mem_pc_o, m_pc[2], "R3 mem_pc");
    if (m_v[3]) chk(wb_pc_o, m_pc[3], "R5 wb_pc");
    @(posedge clk);
    m_v[3] = m_v[2]; m_pc[3] = m_pc[2];
    m_v[2] = m_v[1] & ~eex; m_pc[2] = m_pc[1];
    m_v[1] = m_v[0] & ~tk & ~(st & ~tk); m_pc[1] = m_pc[0];
    if (tk) m_v[0] = 1'b0;
    else if (!st) begin m_v[0] = fv; m_pc[0] = fpc; end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin m_v[i] = 1'b0; m_pc[i] = '0; end
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(PC_W'({id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o}), '0, "R1 valids");
    chk(PC_W'({take_exc_o, flush_if_o, flush_id_o, flush_ex_o, pc_sel_handler_o}), '0, "R1 strobes");
    rst_n = 1'b1;
    @(negedge clk);

    // R10: plain flow
    cyc(1, 32'h40, 0, 0, 0);
    cyc(1, 32'h44, 0, 0, 0);
    cyc(1, 32'h48, 0, 0, 0);
    cyc(1, 32'h4c, 0, 0, 0);
    // R2: overflow in execute (pc 0x48)
    cyc(1, 32'h50, 0, 0, 1);
    cyc(1, 32'h80000180, 0, 0, 0);
    cyc(1, 32'h80000184, 0, 0, 0);
    cyc(1, 32'h80000188, 0, 0, 0);
    // R4: both stages fault together
    cyc(1, 32'h8000018c, 0, 1, 1);
    cyc(1, 32'h100, 0, 0, 0);
    cyc(1, 32'h104, 0, 0, 0);
    // R3: undefined opcode in decode, older instruction survives
    cyc(1, 32'h108, 0, 1, 0);
    cyc(1, 32'h200, 0, 0, 0);
    // R8: fault inputs on empty stages
    cyc(0, 32'h0, 0, 0, 0);
    cyc(0, 32'h0, 0, 0, 0);
    cyc(0, 32'h0, 0, 1, 1);
    // R9: stall hold then stall during a fault
    cyc(1, 32'h300, 0, 0, 0);
    cyc(1, 32'h304, 0, 0, 0);
    cyc(1, 32'h308, 1, 0, 0);
    cyc(1, 32'h308, 1, 0, 0);
    cyc(1, 32'h30c, 1, 1, 0);
    cyc(1, 32'h400, 0, 0, 0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic fv, st, und, ovf;
      fv  = ($urandom % 8) != 0;
      st  = ($urandom % 6) == 0;
      und = ($urandom % 9) == 0;
      ovf = ($urandom % 9) == 0;
      cyc(fv, {$urandom} & 32'hffff_fffc, st, und, ovf);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule